// File: doc/BRIEF.md
# DMA Burst Register Window

This block lets a DMA engine rewrite, or read back, a run of consecutive registers through a single fixed bus address called the window. Software programs a control word with three fields: the index of the first register in the run, a transfer count, and a mask that says which internal trigger events may start a run. When an enabled event fires and the block is idle, it raises a DMA request. Each access the DMA engine makes to the window is redirected to the register the block currently targets. The target then moves to the next register, and the next request goes out once the previous one has been served. One event produces a run of count+1 transfers.

The block holds a small internal register file that stands in for the registers of a timer. The same bus port also reaches those registers directly at their own addresses. Only one request is ever outstanding. A request stays high until the window access that serves it, and there is always one idle cycle before the next request. The start index and count are captured when a run begins, so rewriting the control word during a run only affects the next run.

Top module: `dma_burst_window`

## Requirements
- R1: After reset, dma_req_o and busy_o are low and every internal register and the control word read as zero.
- R2: With the default parameters, bus word addresses 0 to 7 read and write the eight internal registers directly. Address 8 is the control word: start index in bits 2:0, transfer count in bits 10:8, event enable mask in bits 19:16, and all other written bits ignored.
- R3: A run starts only on a cycle where some bit of evt_i and the same bit of the enable mask are both 1 while the block is idle. busy_o and dma_req_o are high from the next clock edge.
- R4: A transfer count of N produces exactly N+1 requests per run. busy_o stays high until the clock edge that takes the last window access and is low after it.
- R5: Window accesses k = 0 to N of a run target register start+k. Writes at address 9 land there, and reads at address 9 return that register's value in the same cycle.
- R6: A request stays high until the window access that serves it. It is low in the cycle after that access, and high again one cycle later if transfers remain.
- R7: A trigger event that arrives while a run is in progress has no effect on that run's length or targets, and no extra run follows.
- R8: A control word written during a run does not change that run. The next run uses the new start index and count.
- R9: A transfer whose target index is past the last register still counts as a transfer. Its write is discarded and its read returns zero.
- R10: A window access made while no request is pending writes nothing, reads zero and does not advance the run.
- R11: A trigger after a run has completed repeats the whole sequence from the configured start index.
- R12: Reading the control word returns the busy state in bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | AW (4) | Word address: registers, control word, window |
| bus_wdata | input | DW (32) | Write data |
| bus_rdata | output | DW (32) | Read data, same cycle as the access |
| evt_i | input | NEVT (4) | Internal trigger event pulses |
| dma_req_o | output | 1 | DMA request, held until served |
| busy_o | output | 1 | Run in progress |

## Verification
The bench sweeps every start index against every transfer count, first with write runs and then with read runs. After each run it compares the whole register file with a model. This catches an off-by-one count, which would leave one register stale or overwrite a neighbour. It also catches a pointer that wraps instead of discarding, which would corrupt the low registers when a run starts near the top. Every event bit is paired with every enable mask, so a design that ignores the mask, or lets any event start a run, would raise a request that should not exist. Further tests fire triggers mid-run, rewrite the control word mid-run and access the window while idle. A design that restarted, extended or redirected a live run, or let a stray window write reach a register, would show a wrong request count or wrong register contents.

// File: rtl/dbw_pkg.sv
package dbw_pkg;

  // Control word field positions (neighbours decode these)
  localparam int CFG_START_LSB = 0;
  localparam int CFG_CNT_LSB   = 8;
  localparam int CFG_EN_LSB    = 16;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_REQ  = 2'd1,
    SEQ_GAP  = 2'd2
  } seq_state_e;

endpackage

// File: rtl/dbw_rst_sync.sv
module dbw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= {sync_q[0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[1];

endmodule

// File: rtl/dbw_cfg_reg.sv
module dbw_cfg_reg #(
  parameter int IDX_W = 3,
  parameter int CNT_W = 3,
  parameter int NEVT  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] start_in,
  input  logic [CNT_W-1:0] cnt_in,
  input  logic [NEVT-1:0]  en_in,
  output logic [IDX_W-1:0] start_q,
  output logic [CNT_W-1:0] cnt_q,
  output logic [NEVT-1:0]  en_q
);

  logic [IDX_W-1:0] start_d;
  logic [CNT_W-1:0] cnt_d;
  logic [NEVT-1:0]  en_d;

  always_comb begin
    start_d = start_q;
    cnt_d   = cnt_q;
    en_d    = en_q;
    if (wr_en) begin
      start_d = start_in;
      cnt_d   = cnt_in;
      en_d    = en_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_q <= '0;
      cnt_q   <= '0;
      en_q    <= '0;
    end else if (wr_en) begin
      start_q <= start_d;
      cnt_q   <= cnt_d;
      en_q    <= en_d;
    end
  end

endmodule

// File: rtl/dbw_regfile.sv
module dbw_regfile #(
  parameter int DW    = 32,
  parameter int NREG  = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [DW-1:0]    wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [DW-1:0]    rd_data
);

  logic [DW-1:0] mem_q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          row_we;
    logic [DW-1:0] row_d;

    always_comb begin
      row_we = wr_en && (wr_idx == IDX_W'(g));
      row_d  = row_we ? wr_data : mem_q[g];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mem_q[g] <= '0;
      end else if (row_we) begin
        mem_q[g] <= row_d;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++) begin
      if (rd_idx == IDX_W'(i)) rd_data = mem_q[i];
    end
  end

endmodule

// File: rtl/dbw_burst_seq.sv
module dbw_burst_seq
  import dbw_pkg::*;
#(
  parameter int IDX_W = 3,
  parameter int CNT_W = 3,
  parameter int PTR_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic             ack,
  input  logic [IDX_W-1:0] start,
  input  logic [CNT_W-1:0] count,
  output logic             req_o,
  output logic             busy_o,
  output logic [PTR_W-1:0] ptr_o
);

  seq_state_e       st_q, st_d;
  logic [PTR_W-1:0] ptr_q, ptr_d;
  logic [CNT_W-1:0] rem_q, rem_d;
  logic             seq_en;

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    rem_d = rem_q;
    unique case (st_q)
      SEQ_IDLE: begin
        if (trig) begin
          st_d  = SEQ_REQ;
          ptr_d = PTR_W'(start);
          rem_d = count;
        end
      end
      SEQ_REQ: begin
        if (ack) begin
          if (rem_q == '0) begin
            st_d = SEQ_IDLE;
          end else begin
            st_d  = SEQ_GAP;
            rem_d = rem_q - 1'b1;
            ptr_d = ptr_q + 1'b1;
          end
        end
      end
      SEQ_GAP: st_d = SEQ_REQ;
      default: st_d = SEQ_IDLE;
    endcase
  end

  assign seq_en = (st_q == SEQ_IDLE && trig) || (st_q == SEQ_REQ && ack) ||
                  (st_q == SEQ_GAP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SEQ_IDLE;
      ptr_q <= '0;
      rem_q <= '0;
    end else if (seq_en) begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      rem_q <= rem_d;
    end
  end

  assign req_o  = (st_q == SEQ_REQ);
  assign busy_o = (st_q != SEQ_IDLE);
  assign ptr_o  = ptr_q;

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && !ack |=> req_o);

  // R6
  req_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_o && ack |=> !req_o);

  // R7
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && !ack |=> $stable(ptr_q) && $stable(rem_q));

  // R3
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && trig |=> req_o && (ptr_q == PTR_W'($past(start))));

  // R4
  run_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack && (rem_q == '0) |=> !busy_o);

endmodule

// File: rtl/dma_burst_window.sv
module dma_burst_window
  import dbw_pkg::*;
#(
  parameter int DW    = 32,
  parameter int NREG  = 8,
  parameter int CNT_W = 3,
  parameter int NEVT  = 4,
  parameter int AW    = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_sel,
  input  logic            bus_we,
  input  logic [AW-1:0]   bus_addr,
  input  logic [DW-1:0]   bus_wdata,
  output logic [DW-1:0]   bus_rdata,
  input  logic [NEVT-1:0] evt_i,
  output logic            dma_req_o,
  output logic            busy_o
);

  localparam int IDX_W    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int PTR_W    = ((IDX_W > CNT_W) ? IDX_W : CNT_W) + 1;
  localparam int CFG_ADDR = NREG;
  localparam int BUF_ADDR = NREG + 1;

  logic             rst_i_n;
  logic             hit_reg, hit_cfg, hit_buf;
  logic             ack, tgt_ok;
  logic             rf_we;
  logic [IDX_W-1:0] rf_wr_idx, rf_rd_idx;
  logic [DW-1:0]    rf_rd_data;
  logic [IDX_W-1:0] cfg_start;
  logic [CNT_W-1:0] cfg_cnt;
  logic [NEVT-1:0]  cfg_en;
  logic [DW-1:0]    cfg_rd;
  logic             trig;
  logic             seq_req, seq_busy;
  logic [PTR_W-1:0] seq_ptr;

  dbw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  always_comb begin
    hit_reg = bus_sel && (bus_addr < AW'(NREG));
    hit_cfg = bus_sel && (bus_addr == AW'(CFG_ADDR));
    hit_buf = bus_sel && (bus_addr == AW'(BUF_ADDR));
    ack     = hit_buf && seq_req;
    tgt_ok  = (seq_ptr < PTR_W'(NREG));
    trig    = |(evt_i & cfg_en);
  end

  dbw_cfg_reg #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W),
    .NEVT  (NEVT)
  ) u_cfg (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .wr_en    (hit_cfg && bus_we),
    .start_in (bus_wdata[CFG_START_LSB +: IDX_W]),
    .cnt_in   (bus_wdata[CFG_CNT_LSB +: CNT_W]),
    .en_in    (bus_wdata[CFG_EN_LSB +: NEVT]),
    .start_q  (cfg_start),
    .cnt_q    (cfg_cnt),
    .en_q     (cfg_en)
  );

  dbw_burst_seq #(
    .IDX_W (IDX_W),
    .CNT_W (CNT_W),
    .PTR_W (PTR_W)
  ) u_seq (
    .clk    (clk),
    .rst_n  (rst_i_n),
    .trig   (trig),
    .ack    (ack),
    .start  (cfg_start),
    .count  (cfg_cnt),
    .req_o  (seq_req),
    .busy_o (seq_busy),
    .ptr_o  (seq_ptr)
  );

  always_comb begin
    rf_we     = bus_we && (hit_reg || (ack && tgt_ok));
    rf_wr_idx = hit_reg ? bus_addr[IDX_W-1:0] : seq_ptr[IDX_W-1:0];
    rf_rd_idx = rf_wr_idx;
  end

  dbw_regfile #(
    .DW    (DW),
    .NREG  (NREG),
    .IDX_W (IDX_W)
  ) u_rf (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .wr_en   (rf_we),
    .wr_idx  (rf_wr_idx),
    .wr_data (bus_wdata),
    .rd_idx  (rf_rd_idx),
    .rd_data (rf_rd_data)
  );

  always_comb begin
    cfg_rd = '0;
    cfg_rd[CFG_START_LSB +: IDX_W] = cfg_start;
    cfg_rd[CFG_CNT_LSB +: CNT_W]   = cfg_cnt;
    cfg_rd[CFG_EN_LSB +: NEVT]     = cfg_en;
    cfg_rd[DW-1]                   = seq_busy;
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_reg || (ack && tgt_ok)) bus_rdata = rf_rd_data;
    else if (hit_cfg)               bus_rdata = cfg_rd;
  end

  assign dma_req_o = seq_req;
  assign busy_o    = seq_busy;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_i_n |=> !dma_req_o && !busy_o);

  // R10
  idle_window_chk: assert property (@(posedge clk) disable iff (!rst_i_n)
    hit_buf && !dma_req_o && !busy_o |=> !busy_o);

endmodule

// File: tb/test_dma_burst_window.sv
module test_dma_burst_window;

  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 8;
  localparam logic [3:0] CFG_A = 4'd8;
  localparam logic [3:0] BUF_A = 4'd9;

  logic        clk;
  logic        rst_n;
  logic        sel, we;
  logic [3:0]  addr;
  logic [31:0] wdata, rdata;
  logic [3:0]  evt;
  logic        req, busy;

  logic [31:0] model [NREG];
  int          vectors;
  int          miscompares;
  bit          done;

  dma_burst_window i_dma_burst_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (sel),
    .bus_we    (we),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .evt_i     (evt),
    .dma_req_o (req),
    .busy_o    (busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfg_word(input int s, input int c, input int en);
    return (32'(en) << 16) | (32'(c) << 8) | 32'(s);
  endfunction

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    sel = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    sel = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    sel = 1'b0;
  endtask

  task automatic pulse(input logic [3:0] e);
    evt = e;
    @(negedge clk);
    evt = '0;
  endtask

  task automatic check_regs(input string tag);
    logic [31:0] d;
    for (int i = 0; i < NREG; i++) begin
      bus_read(4'(i), d);
      chk(tag, d, model[i]);
    end
  endtask

  // Serve a run; returns number of requests served
  task automatic serve(input bit wr, input int s, input int c,
                       input logic [31:0] seed, output int nreq);
    int k;
    nreq = 0;
    k = 0;
    for (int guard = 0; guard < 200 && busy; guard++) begin
      if (req) begin
        sel = 1'b1; we = wr; addr = BUF_A; wdata = seed + 32'(k);
        if (!wr) begin
          #1 chk("R5/R9 window read", rdata,
                 (s + k < NREG) ? model[s + k] : 32'h0);
        end
        if (wr && (s + k < NREG)) model[s + k] = seed + 32'(k);
        @(negedge clk);
        sel = 1'b0; we = 1'b0;
        nreq++; k++;
        chk("R6 request low after access", 32'(req), 32'h0);
        chk("R4 busy until last access", 32'(busy), 32'(nreq <= c));
      end else begin
        @(negedge clk);
      end
    end
  endtask

  initial begin
    done = 1'b0;
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    int n;
    vectors = 0; miscompares = 0;
    rst_n = 1'b0; sel = 1'b0; we = 1'b0; addr = '0; wdata = '0; evt = '0;
    for (int i = 0; i < NREG; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1 req after reset", 32'(req), 32'h0);
    chk("R1 busy after reset", 32'(busy), 32'h0);
    bus_read(CFG_A, d);
    chk("R1 control word", d, 32'h0);
    check_regs("R1 register reset");

    // R2 direct access and control fields
    for (int i = 0; i < NREG; i++) begin
      model[i] = 32'hA5000000 + 32'(i * 17);
      bus_write(4'(i), model[i]);
    end
    check_regs("R2 direct register access");
    bus_write(CFG_A, 32'h7FFF_FFFF);
    bus_read(CFG_A, d);
    chk("R2 control fields", d, cfg_word(7, 7, 15));

    // R10 window access with no request pending
    bus_write(CFG_A, cfg_word(2, 1, 1));
    bus_write(BUF_A, 32'hDEAD_BEEF);
    bus_read(BUF_A, d);
    chk("R10 idle window read", d, 32'h0);
    chk("R10 no request", 32'(req), 32'h0);
    check_regs("R10 idle window write discarded");
    pulse(4'b0001);
    serve(1'b1, 2, 1, 32'h1000_0000, n);
    chk("R10 run still starts at start index", 32'(n), 32'd2);
    check_regs("R10 targets after idle access");

    // R3 event gating sweep
    for (int e = 0; e < 4; e++) begin
      for (int m = 0; m < 16; m++) begin
        bus_write(CFG_A, cfg_word(0, 0, m));
        pulse(4'(1 << e));
        chk("R3 gated start busy", 32'(busy), 32'(m[e]));
        chk("R3 gated start req", 32'(req), 32'(m[e]));
        if (busy) serve(1'b0, 0, 0, 32'h0, n);
      end
    end

    // R4 R5 R9 R11 full sweep of start and count
    for (int s = 0; s < NREG; s++) begin
      for (int c = 0; c < 8; c++) begin
        bus_write(CFG_A, cfg_word(s, c, 2));
        pulse(4'b0010);
        chk("R3 run started", 32'(busy), 32'h1);
        serve(1'b1, s, c, 32'(s * 256 + c * 16) + 32'h5000_0000, n);
        chk("R4 request count write run", 32'(n), 32'(c + 1));
        check_regs("R5/R9/R11 register contents");
        pulse(4'b0010);
        serve(1'b0, s, c, 32'h0, n);
        chk("R4 request count read run", 32'(n), 32'(c + 1));
      end
    end

    // R7 trigger during run ignored
    bus_write(CFG_A, cfg_word(1, 3, 4));
    pulse(4'b0100);
    pulse(4'b0100);
    serve(1'b1, 1, 3, 32'h7000_0000, n);
    chk("R7 run length unchanged", 32'(n), 32'd4);
    repeat (2) @(negedge clk);
    chk("R7 no extra run", 32'(busy), 32'h0);
    check_regs("R7 targets unchanged");

    // R8 control change mid-run, R12 busy readable
    bus_write(CFG_A, cfg_word(0, 1, 1));
    pulse(4'b0001);
    bus_read(CFG_A, d);
    chk("R12 busy bit in control word", d, cfg_word(0, 1, 1) | 32'h8000_0000);
    bus_write(CFG_A, cfg_word(5, 0, 1));
    serve(1'b1, 0, 1, 32'h8000_0000, n);
    chk("R8 old count kept", 32'(n), 32'd2);
    check_regs("R8 old start kept");
    bus_read(CFG_A, d);
    chk("R12 busy clear after run", d, cfg_word(5, 0, 1));
    pulse(4'b0001);
    serve(1'b1, 5, 0, 32'h9000_0000, n);
    chk("R8 new count used", 32'(n), 32'd1);
    check_regs("R8 new start used");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule